// File: doc/BRIEF.md
# Byte-Addressed Memory Controller with Start/Ready Handshake

This block sits between a small processor core and the on-chip storage it runs from. The core presents one request: an address, a write word, a width code, a sign-extension flag, a write enable and a start strobe. The controller answers with a read word and a one-cycle ready strobe. A single contiguous address space is split into three targets. The lowest 4 KB is a read-only region whose contents are a fixed function of the address. The byte at 0x1000 is a one-bit output register that drives a pin. The bytes from 0x1001 up to 0x1FFF are read/write RAM.

Byte, halfword and word transfers are supported. The low address bits choose the lane within a little-endian 32-bit word. Narrow reads are zero-extended, or sign-extended when the flag is set. Each request is taken when the controller is idle. Ready comes back exactly once, two clock edges after the request was sampled. At that point the read word is valid, or the write has landed in storage.

Top module: `bytemem_ctrl`

## Requirements
- R1: When `req_start` is high at a rising edge while the controller is idle, the request is taken. `rsp_ready` is then high for exactly one cycle, the cycle after the next rising edge. It is low at every other time.
- R2: A `req_start` that is sampled while a request is in progress is ignored. Its fields cause no write and no further ready pulse.
- R3: Word reads and writes to RAM use a little-endian byte order. On a read the write-data input has no effect on storage.
- R4: A byte transfer (`req_size`=0) uses lane `addr[1:0]`: lane 0 holds bits 7:0 and lane 3 holds bits 31:24. A byte write stores only `req_wdata[7:0]` and leaves the other three bytes of the word unchanged.
- R5: A halfword transfer (`req_size`=1) uses bits 15:0 when `addr[1]`=0 and bits 31:16 when `addr[1]`=1. A halfword write stores only `req_wdata[15:0]`.
- R6: On a byte or halfword read, `req_sext`=1 copies the top bit of the selected data into all higher bits of `rsp_rdata`. `req_sext`=0 fills those bits with zero. The flag has no effect on writes.
- R7: Addresses 0x0000–0x0FFF are read-only. The byte at address a reads as a[7:0] XOR {a[11:8],a[11:8]} XOR 0x96. Writes to this region are discarded.
- R8: Address 0x1000 is the pin register. A write of any width there sets `gpio_out` to `req_wdata[0]` in the cycle `rsp_ready` is high. A read there returns the pin value in bit 0 and zero in bits 31:1. The pin changes at no other time.
- R9: An address at or above 0x2000 reads as zero, and a write to it is discarded. It does not alias onto RAM.
- R10: While reset is low, `rsp_ready`, `rsp_rdata` and `gpio_out` are 0.
- R11: Width code 3 behaves exactly like width code 2 (a 32-bit word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data, taken from the low bits |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_sext | input | 1 | Sign-extend narrow reads |
| req_we | input | 1 | 1 write, 0 read |
| req_start | input | 1 | Request strobe, sampled on the rising edge |
| rsp_rdata | output | 32 | Read result, valid while rsp_ready is high |
| rsp_ready | output | 1 | One-cycle completion strobe |
| gpio_out | output | 1 | Memory-mapped output pin |

## Verification
The stimulus table starts by writing a word whose top bit in each lane differs. It then reads that word back at every width and lane, with and without sign extension. This separates lane selection errors from extension errors. Later byte and halfword writes carry wdata whose upper bits are nonzero, and a full-word read follows each one, which exposes any spill of unused write bits or a wrong lane mask. Further requests go to the read-only region, to an address above the map and to the pin register. A read of the nearby RAM word after each shows that no write leaked across a region boundary. A start held through the busy cycle, with its fields changed to a write, checks that a second request is not taken.

// File: rtl/bytemem_ctrl.sv
module bytemem_ctrl #(
  parameter int unsigned ROM_BYTES = 4096,
  parameter int unsigned RAM_BYTES = 4096,
  parameter logic [7:0]  ROM_SEED  = 8'h96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [1:0]  req_size,
  input  logic        req_sext,
  input  logic        req_we,
  input  logic        req_start,
  output logic [31:0] rsp_rdata,
  output logic        rsp_ready,
  output logic        gpio_out
);

  localparam logic [31:0] PIN_ADDR  = 32'(ROM_BYTES);
  localparam logic [31:0] MAP_LIMIT = 32'(ROM_BYTES + RAM_BYTES);
  localparam int unsigned RAM_WORDS = RAM_BYTES / 4;
  localparam int unsigned RIDX_W    = $clog2(RAM_WORDS);

  logic        busy;
  logic [31:0] q_addr, q_wdata;
  logic [1:0]  q_size;
  logic        q_sext, q_we;
  logic [31:0] ram [RAM_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_size  <= '0;
      q_sext  <= 1'b0;
      q_we    <= 1'b0;
    end else if (!busy && req_start) begin
      busy    <= 1'b1;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
      q_size  <= req_size;
      q_sext  <= req_sext;
      q_we    <= req_we;
    end else begin
      busy    <= 1'b0;
    end
  end

  function automatic logic [7:0] rom_byte(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ ROM_SEED;
  endfunction

  logic              hit_rom, hit_pin, hit_ram;
  logic [31:0]       ram_off;
  logic [RIDX_W-1:0] ridx;
  logic [31:0]       rom_word, ram_word, raw, rd_val;
  logic [7:0]        sel_b;
  logic [15:0]       sel_h;
  logic [3:0]        lane_mask, wr_mask;
  logic [31:0]       wr_lanes;

  assign hit_rom = q_addr < PIN_ADDR;
  assign hit_pin = q_addr == PIN_ADDR;
  assign hit_ram = (q_addr > PIN_ADDR) && (q_addr < MAP_LIMIT);
  assign ram_off = q_addr - PIN_ADDR;
  assign ridx    = RIDX_W'(ram_off >> 2);

  assign rom_word = {rom_byte({q_addr[11:2], 2'd3}), rom_byte({q_addr[11:2], 2'd2}),
                     rom_byte({q_addr[11:2], 2'd1}), rom_byte({q_addr[11:2], 2'd0})};
  assign ram_word = (ridx == '0) ? {ram[ridx][31:8], 8'h00} : ram[ridx];

  always_comb begin
    if (hit_rom)      raw = rom_word;
    else if (hit_pin) raw = {31'b0, gpio_out};
    else if (hit_ram) raw = ram_word;
    else              raw = '0;
  end

  assign sel_b = raw[{q_addr[1:0], 3'b000} +: 8];
  assign sel_h = raw[{q_addr[1], 4'b0000} +: 16];

  always_comb begin
    case (q_size)
      2'd0:    rd_val = {{24{q_sext & sel_b[7]}}, sel_b};
      2'd1:    rd_val = {{16{q_sext & sel_h[15]}}, sel_h};
      default: rd_val = raw;
    endcase
  end

  always_comb begin
    case (q_size)
      2'd0: begin
        lane_mask = 4'b0001 << q_addr[1:0];
        wr_lanes  = {4{q_wdata[7:0]}};
      end
      2'd1: begin
        lane_mask = q_addr[1] ? 4'b1100 : 4'b0011;
        wr_lanes  = {2{q_wdata[15:0]}};
      end
      default: begin
        lane_mask = 4'b1111;
        wr_lanes  = q_wdata;
      end
    endcase
    wr_mask = lane_mask & ((ridx == '0) ? 4'b1110 : 4'b1111);
  end

  always_ff @(posedge clk) begin
    if (busy && q_we && hit_ram) begin
      for (int b = 0; b < 4; b++) begin
        if (wr_mask[b]) ram[ridx][8*b +: 8] <= wr_lanes[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
      gpio_out  <= 1'b0;
    end else begin
      rsp_ready <= busy;
      if (busy && !q_we) rsp_rdata <= rd_val;
      if (busy && q_we && hit_pin) gpio_out <= q_wdata[0];
    end
  end

  // R1
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  // R1
  ready_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy) |=> ##1 rsp_ready);

  // R8
  pin_only_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_out) |-> rsp_ready);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !q_we && q_addr >= MAP_LIMIT) |-> rsp_rdata == 32'h0);

  // R6
  byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !q_we && q_size == 2'd0 && q_sext) |-> rsp_rdata[31:8] == {24{rsp_rdata[7]}});

  // R6
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !q_we && q_size == 2'd0 && !q_sext) |-> rsp_rdata[31:8] == 24'h0);

  // R8
  pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !q_we && q_addr == PIN_ADDR) |-> rsp_rdata[31:1] == 31'h0);

endmodule

// File: tb/tb_bytemem_ctrl.sv
module tb_bytemem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_sext = 1'b0, req_we = 1'b0, req_start = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_ready, gpio_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bytemem_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_size(req_size), .req_sext(req_sext), .req_we(req_we), .req_start(req_start),
    .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready), .gpio_out(gpio_out)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic        sx;
    logic [31:0] a;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 1'b0, 32'h1004, 32'h87654321, 32'h0,        8'd3},  // R3
    '{1'b0, 2'd2, 1'b0, 32'h1004, 32'h0,        32'h87654321, 8'd3},  // R3
    '{1'b0, 2'd0, 1'b0, 32'h1004, 32'h0,        32'h00000021, 8'd4},  // R4
    '{1'b0, 2'd0, 1'b1, 32'h1007, 32'h0,        32'hFFFFFF87, 8'd6},  // R6
    '{1'b0, 2'd0, 1'b0, 32'h1007, 32'h0,        32'h00000087, 8'd6},  // R6
    '{1'b0, 2'd1, 1'b1, 32'h1006, 32'h0,        32'hFFFF8765, 8'd6},  // R6
    '{1'b0, 2'd1, 1'b1, 32'h1004, 32'h0,        32'h00004321, 8'd5},  // R5
    '{1'b1, 2'd0, 1'b0, 32'h1005, 32'hDEADBEEF, 32'h0,        8'd4},  // R4
    '{1'b0, 2'd3, 1'b0, 32'h1004, 32'h0,        32'h8765EF21, 8'd4},  // R4 R11
    '{1'b1, 2'd1, 1'b1, 32'h1006, 32'h1234ABCD, 32'h0,        8'd5},  // R5 R6
    '{1'b0, 2'd2, 1'b0, 32'h1004, 32'h0,        32'hABCDEF21, 8'd5},  // R5
    '{1'b0, 2'd1, 1'b0, 32'h1006, 32'h0,        32'h0000ABCD, 8'd6},  // R6
    '{1'b0, 2'd1, 1'b1, 32'h1006, 32'h0,        32'hFFFFABCD, 8'd6},  // R6
    '{1'b1, 2'd3, 1'b0, 32'h1008, 32'h000000FF, 32'h0,        8'd11}, // R11
    '{1'b0, 2'd0, 1'b1, 32'h1008, 32'h0,        32'hFFFFFFFF, 8'd6},  // R6
    '{1'b0, 2'd2, 1'b0, 32'h1008, 32'h0,        32'h000000FF, 8'd11}, // R11
    '{1'b1, 2'd2, 1'b0, 32'h0010, 32'h11111111, 32'h0,        8'd7},  // R7
    '{1'b0, 2'd2, 1'b0, 32'h0010, 32'h0,        32'h85848786, 8'd7},  // R7
    '{1'b0, 2'd0, 1'b1, 32'h0000, 32'h0,        32'hFFFFFF96, 8'd7},  // R7
    '{1'b0, 2'd1, 1'b1, 32'h0002, 32'h0,        32'hFFFF9594, 8'd7},  // R7
    '{1'b0, 2'd0, 1'b0, 32'h0F23, 32'h0,        32'h0000004A, 8'd7},  // R7
    '{1'b1, 2'd2, 1'b0, 32'h3004, 32'hCAFEF00D, 32'h0,        8'd9},  // R9
    '{1'b0, 2'd2, 1'b0, 32'h3004, 32'h0,        32'h00000000, 8'd9},  // R9
    '{1'b0, 2'd2, 1'b0, 32'h1004, 32'h55555555, 32'hABCDEF21, 8'd3}   // R3 R9
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic xact(input logic we, input logic [1:0] sz, input logic sx,
                      input logic [31:0] a, input logic [31:0] wd,
                      output logic [31:0] rd);
    logic r0, r1;
    @(negedge clk);
    req_we = we; req_size = sz; req_sext = sx; req_addr = a; req_wdata = wd;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    r0 = rsp_ready;
    @(negedge clk);
    r1 = rsp_ready;
    rd = rsp_rdata;
    check("R1 latency", {30'b0, r0, r1}, 32'h1);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int pulses;
    repeat (3) @(negedge clk);
    // R10
    check("R10 ready", {31'b0, rsp_ready}, 32'h0);
    check("R10 rdata", rsp_rdata, 32'h0);
    check("R10 pin", {31'b0, gpio_out}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i].we, VEC[i].sz, VEC[i].sx, VEC[i].a, VEC[i].wd, rd);
      if (!VEC[i].we) check($sformatf("R%0d row %0d", VEC[i].rq, i), rd, VEC[i].exp);
    end

    // R1: the strobe drops after one cycle
    @(negedge clk);
    check("R1 single pulse", {31'b0, rsp_ready}, 32'h0);

    // R8: pin register
    xact(1'b1, 2'd0, 1'b0, 32'h1000, 32'h00000003, rd);
    check("R8 pin set", {31'b0, gpio_out}, 32'h1);
    xact(1'b0, 2'd2, 1'b0, 32'h1000, 32'h0, rd);
    check("R8 pin read", rd, 32'h1);
    xact(1'b1, 2'd1, 1'b0, 32'h1000, 32'h0000FFFE, rd);
    check("R8 pin clear", {31'b0, gpio_out}, 32'h0);
    xact(1'b0, 2'd0, 1'b1, 32'h1000, 32'h0, rd);
    check("R8 pin read low", rd, 32'h0);
    xact(1'b1, 2'd2, 1'b0, 32'h1000, 32'hFFFFFFFF, rd);
    check("R8 word set", {31'b0, gpio_out}, 32'h1);
    xact(1'b0, 2'd2, 1'b0, 32'h1004, 32'h0, rd);
    check("R8 RAM untouched", rd, 32'hABCDEF21);
    xact(1'b0, 2'd2, 1'b0, 32'h0010, 32'h0, rd);
    check("R8 pin held over reads", {31'b0, gpio_out}, 32'h1);

    // R2: start held through the busy cycle with fields turned into a write
    xact(1'b1, 2'd2, 1'b0, 32'h100C, 32'h0, rd);
    @(negedge clk);
    req_we = 1'b0; req_size = 2'd2; req_sext = 1'b0; req_addr = 32'h1004; req_start = 1'b1;
    @(negedge clk);
    req_we = 1'b1; req_addr = 32'h100C; req_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    req_start = 1'b0;
    pulses = 0;
    for (int c = 0; c < 5; c++) begin
      if (rsp_ready) pulses++;
      @(negedge clk);
    end
    check("R2 one ready", 32'(pulses), 32'h1);
    xact(1'b0, 2'd2, 1'b0, 32'h100C, 32'h0, rd);
    check("R2 no write", rd, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule